// File: doc/BRIEF.md
# EEPROM Station Address Loader

This block refreshes a 48-bit station address from a byte-addressed configuration EEPROM. The host raises a single-cycle reload command. The loader then reads a signature byte from EEPROM address 0. A programmed part must hold 0xA5 there. If the signature matches, the loader reads the six address bytes from addresses 1 to 6 and places all of them into the output register in one cycle.

Three status outputs report the result. The address-loaded bit shows that the register holds a verified address. The completion bit marks a finished successful reload. The fail bit covers two cases: a bad signature, and an EEPROM engine that does not answer within a host-programmed number of cycles. The EEPROM side uses a simple request/acknowledge byte-read port, so the serial protocol engine sits outside this block.

Top module: `mac_addr_loader`

## Requirements
- R1: After reset, busy, rd_req, addr_loaded, load_done and load_fail are 0, and station_addr is all zeros.
- R2: A reload_cmd sampled while idle is accepted. busy is 1 from the next cycle and stays 1 until the cycle after the sequence ends.
- R3: A reload_cmd sampled while busy is ignored. The read sequence, the flags and the result are exactly what they would be without it.
- R4: Only one read is outstanding at a time. rd_req is high exactly while busy, and rd_addr holds steady until rd_ack. The addresses issued are 0, 1, 2, 3, 4, 5, 6 in that order, and each new address starts in the cycle after the previous rd_ack.
- R5: If the byte returned for address 0 is not 0xA5, the sequence ends at once. No further reads are issued, load_fail and addr_loaded become 1 and 0 respectively, and station_addr is unchanged.
- R6: On success, station_addr holds the byte from address 1 in bits 7:0, the byte from address 2 in bits 15:8, and so on up to the byte from address 6 in bits 47:40.
- R7: station_addr changes only in the cycle after the final acknowledge of a successful sequence, and all 48 bits change in that single update.
- R8: addr_loaded becomes 1 after a success and 0 after any failure. Accepting a command does not change it.
- R9: Accepting a command clears load_done and load_fail. A success sets load_done and leaves load_fail at 0.
- R10: If a pending read sees no rd_ack for timeout_cycles consecutive cycles, the sequence fails as in R5: load_fail is 1, addr_loaded is 0 and station_addr is unchanged. A timeout_cycles value of 0 acts as 1, and an rd_ack arriving in the last allowed cycle is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reload_cmd | input | 1 | Single-cycle reload request from the host |
| timeout_cycles | input | TW (16) | Maximum wait, in cycles, for each byte read |
| busy | output | 1 | Reload sequence in progress |
| addr_loaded | output | 1 | station_addr holds a verified address |
| load_done | output | 1 | Last reload completed successfully |
| load_fail | output | 1 | Last reload failed on the signature or on a timeout |
| rd_req | output | 1 | Byte read request toward the EEPROM engine |
| rd_addr | output | AW (8) | EEPROM byte address of the request |
| rd_ack | input | 1 | Read data valid, one cycle per request |
| rd_data | input | 8 | Byte returned with rd_ack |
| station_addr | output | 48 | Loaded station address |

## Verification
A wrong read index shows up on rd_addr in the very next cycle, long before the address would be corrupted. For that reason the per-cycle comparison of rd_req and rd_addr against the reference model catches ordering and hold errors without waiting for the end of the sequence. A shadow register that is mis-steered, or a commit that fires early, appears on station_addr either as a change in the middle of a sequence or as a wrong final value one cycle after the last acknowledge. A fault in the timeout counter shifts the cycle in which busy falls by at least one, and the bench tests this with latencies on both sides of the limit, including a limit of 0.

// File: rtl/mal_pkg.sv
package mal_pkg;
  localparam int MAC_BYTES = 6;
  localparam int MAC_W     = 8 * MAC_BYTES;
  localparam int SLOT_W    = $clog2(MAC_BYTES + 1);

  // Return cur with byte lane 'slot' replaced by b (lane 0 = bits 7:0).
  function automatic logic [MAC_W-1:0] place_byte(input logic [MAC_W-1:0]  cur,
                                                  input logic [SLOT_W-1:0] slot,
                                                  input logic [7:0]        b);
    logic [MAC_W-1:0] r;
    r = cur;
    for (int i = 0; i < MAC_BYTES; i++) begin
      if (slot == SLOT_W'(i)) r[8*i +: 8] = b;
    end
    return r;
  endfunction

  // Signature comparison for the programmed-part marker.
  function automatic logic sig_match(input logic [7:0] b, input logic [7:0] sig);
    return b == sig;
  endfunction
endpackage

// File: rtl/mal_seq.sv
module mal_seq #(
  parameter int          AW  = 8,
  parameter logic [7:0]  SIG = 8'hA5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reload_cmd,
  input  logic                      rd_ack,
  input  logic [7:0]                rd_data,
  input  logic                      timeout_hit,
  output logic                      busy,
  output logic                      rd_req,
  output logic [AW-1:0]             rd_addr,
  output logic                      accept,
  output logic                      ack_take,
  output logic                      byte_we,
  output logic [mal_pkg::SLOT_W-1:0] byte_slot,
  output logic                      commit,
  output logic                      fail_evt,
  output logic                      sig_bad
);
  localparam int IW = mal_pkg::SLOT_W;
  localparam int NB = mal_pkg::MAC_BYTES;

  logic          fetching;
  logic [IW-1:0] idx;
  logic          at_sig;
  logic          at_last;

  assign busy      = fetching;
  assign rd_req    = fetching;
  assign rd_addr   = AW'(idx);
  assign at_sig    = (idx == '0);
  assign at_last   = (idx == IW'(NB));
  assign accept    = reload_cmd & ~fetching;
  assign ack_take  = fetching & rd_ack;
  assign sig_bad   = ack_take & at_sig & ~mal_pkg::sig_match(rd_data, SIG);
  assign byte_we   = ack_take & ~at_sig;
  assign byte_slot = idx - IW'(1);
  assign commit    = ack_take & at_last;
  assign fail_evt  = sig_bad | (fetching & ~rd_ack & timeout_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetching <= 1'b0;
      idx      <= '0;
    end else if (accept) begin
      fetching <= 1'b1;
      idx      <= '0;
    end else if (fetching) begin
      if (commit || fail_evt) fetching <= 1'b0;
      else if (ack_take)      idx      <= idx + IW'(1);
    end
  end

  assert_busy_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !timeout_hit) |=> (rd_req && $stable(rd_addr)));
  assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr <= AW'(NB)));
  assert_stop_after_bad_sig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sig_bad |=> !rd_req);
  assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit, fail_evt}));
endmodule

// File: rtl/mal_timer.sv
module mal_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          waiting,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          timeout_hit
);
  logic [TW-1:0] wait_cnt;

  // True when the current waiting cycle is the last one allowed.
  function automatic logic limit_reached(input logic [TW-1:0] cnt, input logic [TW-1:0] lim);
    logic [TW:0] next_cnt;
    next_cnt = {1'b0, cnt} + (TW+1)'(1);
    return next_cnt >= {1'b0, lim};
  endfunction

  assign timeout_hit = waiting & limit_reached(wait_cnt, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       wait_cnt <= '0;
    else if (restart)                 wait_cnt <= '0;
    else if (waiting && !timeout_hit) wait_cnt <= wait_cnt + TW'(1);
  end
endmodule

// File: rtl/mal_addr_reg.sv
module mal_addr_reg (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        byte_we,
  input  logic [mal_pkg::SLOT_W-1:0]  byte_slot,
  input  logic [7:0]                  wdata,
  input  logic                        commit,
  output logic [mal_pkg::MAC_W-1:0]   station_addr
);
  logic [mal_pkg::MAC_W-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow       <= '0;
      station_addr <= '0;
    end else begin
      if (byte_we) shadow       <= mal_pkg::place_byte(shadow, byte_slot, wdata);
      if (commit)  station_addr <= mal_pkg::place_byte(shadow, byte_slot, wdata);
    end
  end

  assert_addr_atomic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(station_addr));
endmodule

// File: rtl/mal_status.sv
module mal_status (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic commit,
  input  logic fail_evt,
  output logic addr_loaded,
  output logic load_done,
  output logic load_fail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_loaded <= 1'b0;
      load_done   <= 1'b0;
      load_fail   <= 1'b0;
    end else if (accept) begin
      load_done <= 1'b0;
      load_fail <= 1'b0;
    end else if (commit) begin
      addr_loaded <= 1'b1;
      load_done   <= 1'b1;
    end else if (fail_evt) begin
      addr_loaded <= 1'b0;
      load_fail   <= 1'b1;
    end
  end

  assert_fail_drops_loaded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> (load_fail && !addr_loaded && !load_done));
  assert_success_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (addr_loaded && load_done && !load_fail));
  assert_accept_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!load_done && !load_fail && $stable(addr_loaded)));
endmodule

// File: rtl/mac_addr_loader.sv
module mac_addr_loader #(
  parameter int         AW  = 8,
  parameter int         TW  = 16,
  parameter logic [7:0] SIG = 8'hA5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reload_cmd,
  input  logic [TW-1:0]             timeout_cycles,
  output logic                      busy,
  output logic                      addr_loaded,
  output logic                      load_done,
  output logic                      load_fail,
  output logic                      rd_req,
  output logic [AW-1:0]             rd_addr,
  input  logic                      rd_ack,
  input  logic [7:0]                rd_data,
  output logic [mal_pkg::MAC_W-1:0] station_addr
);
  logic                       accept;
  logic                       ack_take;
  logic                       byte_we;
  logic [mal_pkg::SLOT_W-1:0] byte_slot;
  logic                       commit;
  logic                       fail_evt;
  logic                       sig_bad;
  logic                       timeout_hit;

  mal_seq #(.AW(AW), .SIG(SIG)) seq_i (
    .clk(clk), .rst_n(rst_n), .reload_cmd(reload_cmd), .rd_ack(rd_ack),
    .rd_data(rd_data), .timeout_hit(timeout_hit), .busy(busy), .rd_req(rd_req),
    .rd_addr(rd_addr), .accept(accept), .ack_take(ack_take), .byte_we(byte_we),
    .byte_slot(byte_slot), .commit(commit), .fail_evt(fail_evt), .sig_bad(sig_bad)
  );

  mal_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .waiting(busy), .restart(accept | ack_take),
    .limit(timeout_cycles), .timeout_hit(timeout_hit)
  );

  mal_addr_reg addr_i (
    .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .byte_slot(byte_slot),
    .wdata(rd_data), .commit(commit), .station_addr(station_addr)
  );

  mal_status status_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .commit(commit), .fail_evt(fail_evt),
    .addr_loaded(addr_loaded), .load_done(load_done), .load_fail(load_fail)
  );

  assert_timeout_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_hit && !rd_ack) |=> (!busy && load_fail));
endmodule

// File: tb/mac_addr_loader_tb_top.sv
module mac_addr_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd = 1'b0;
  logic [15:0] tcyc = 16'd8;
  logic        ack = 1'b0;
  logic [7:0]  data = 8'h00;
  logic        busy, loaded, done, fail, rd_req;
  logic [7:0]  rd_addr;
  logic [47:0] station_addr;

  always #2 clk = ~clk;

  mac_addr_loader dut_i (
    .clk(clk), .rst_n(rst_n), .reload_cmd(cmd), .timeout_cycles(tcyc),
    .busy(busy), .addr_loaded(loaded), .load_done(done), .load_fail(fail),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(ack), .rd_data(data),
    .station_addr(station_addr)
  );

  int unsigned nchk = 0, nfail = 0;
  bit          finished = 0;
  bit          model_live = 0;

  // behavioural EEPROM
  logic [7:0] mem [0:7];
  int         lat = 0;
  int         rwait = 0;
  int         req_cycles = 0;

  // reference model
  bit          m_busy, m_loaded, m_done, m_fail;
  int          m_idx, m_wait;
  logic [47:0] m_mac, m_shadow;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_loaded = 0; m_done = 0; m_fail = 0;
      m_idx = 0; m_wait = 0; m_mac = '0; m_shadow = '0;
      model_live = 1;
    end else if (!m_busy) begin
      if (cmd) begin
        m_busy = 1; m_idx = 0; m_wait = 0; m_done = 0; m_fail = 0;
      end
    end else if (ack) begin
      if (m_idx == 0 && data != 8'hA5) begin
        m_busy = 0; m_fail = 1; m_loaded = 0;
      end else begin
        if (m_idx >= 1) m_shadow[8*(m_idx-1) +: 8] = data;
        if (m_idx == 6) begin
          m_mac = m_shadow; m_loaded = 1; m_done = 1; m_busy = 0;
        end else begin
          m_idx = m_idx + 1; m_wait = 0;
        end
      end
    end else if (m_wait + 1 >= int'(tcyc)) begin
      m_busy = 0; m_fail = 1; m_loaded = 0;
    end else begin
      m_wait = m_wait + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(busy == m_busy, "R2 busy", 64'(busy), 64'(m_busy));
    chk(rd_req == m_busy, "R4 rd_req", 64'(rd_req), 64'(m_busy));
    if (m_busy) chk(rd_addr == 8'(m_idx), "R4 rd_addr", 64'(rd_addr), 64'(m_idx));
    chk(station_addr == m_mac, "R6 station_addr", 64'(station_addr), 64'(m_mac));
    chk(loaded == m_loaded, "R8 addr_loaded", 64'(loaded), 64'(m_loaded));
    chk({done, fail} == {m_done, m_fail}, "R9 done/fail", 64'({done, fail}), 64'({m_done, m_fail}));
  endtask

  // one cycle: compare at the falling edge, then drive the next inputs
  task automatic step(input bit c);
    @(negedge clk);
    if (model_live && rst_n) compare_all();
    cmd = c;
    if (rd_req) begin
      req_cycles++;
      if (rwait >= lat) begin
        ack = 1'b1; data = mem[rd_addr[2:0]]; rwait = 0;
      end else begin
        ack = 1'b0; data = 8'h00; rwait++;
      end
    end else begin
      ack = 1'b0; data = 8'h00; rwait = 0;
    end
  endtask

  task automatic run_seq(input int extra_at, input logic [47:0] mac_before);
    int n;
    req_cycles = 0;
    step(1'b1);
    step(1'b0);
    n = 0;
    while (m_busy && n < 2000) begin
      step(n == extra_at);
      if (m_busy) chk(station_addr == mac_before, "R7 mid-sequence hold", 64'(station_addr), 64'(mac_before));
      n++;
    end
    step(1'b0);
  endtask

  task automatic load_good(input logic [7:0] base);
    mem[0] = 8'hA5;
    for (int i = 1; i <= 6; i++) mem[i] = base + 8'(i * 8'h11);
    mem[7] = 8'hFF;
  endtask

  initial begin
    logic [47:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({busy, rd_req, loaded, done, fail} == 5'b0, "R1 flags after reset", 64'({busy, rd_req, loaded, done, fail}), 64'h0);
    chk(station_addr == 48'h0, "R1 address after reset", 64'(station_addr), 64'h0);

    // R6 basic success, zero latency
    load_good(8'h00); lat = 0; tcyc = 16'd8;
    run_seq(-1, 48'h0);
    chk(station_addr == 48'h665544332211, "R6 byte order", 64'(station_addr), 64'h665544332211);
    chk(loaded && done && !fail, "R8 R9 success flags", 64'({loaded, done, fail}), 64'b110);

    // R3 ignored command mid-sequence, latency 2; R7 atomic update
    prev = station_addr; load_good(8'h20); lat = 2;
    run_seq(5, prev);
    chk(station_addr == 48'h86_75_64_53_42_31, "R3 R7 result with extra command", 64'(station_addr), 64'h867564534231);
    chk(!busy, "R3 no second sequence", 64'(busy), 64'h0);

    // R5 bad signature
    prev = station_addr; mem[0] = 8'h5A; lat = 1;
    run_seq(-1, prev);
    chk(req_cycles == 2, "R5 only signature read issued", 64'(req_cycles), 64'd2);
    chk(fail && !loaded && !done, "R5 failure flags", 64'({fail, loaded, done}), 64'b100);
    chk(station_addr == prev, "R5 address unchanged", 64'(station_addr), 64'(prev));

    // R10 no response, limit 5
    load_good(8'h40); lat = 100000; tcyc = 16'd5;
    run_seq(-1, prev);
    chk(req_cycles == 5, "R10 request held for limit cycles", 64'(req_cycles), 64'd5);
    chk(fail && !loaded, "R10 timeout flags", 64'({fail, loaded}), 64'b10);
    chk(station_addr == prev, "R10 address unchanged", 64'(station_addr), 64'(prev));

    // R10 boundary: latency just under the limit succeeds
    lat = 4; tcyc = 16'd5;
    run_seq(-1, prev);
    chk(done && !fail, "R10 ack in last allowed cycle", 64'({done, fail}), 64'b10);
    chk(station_addr == 48'hA6_95_84_73_62_51, "R6 R10 address after boundary", 64'(station_addr), 64'hA69584736251);

    // R10 boundary: latency equal to the limit fails
    prev = station_addr; lat = 5;
    run_seq(-1, prev);
    chk(fail && !done, "R10 ack one cycle late", 64'({fail, done}), 64'b10);

    // R10 limit 0 acts as 1
    lat = 0; tcyc = 16'd0; load_good(8'h60);
    run_seq(-1, prev);
    chk(done && !fail, "R10 zero limit, immediate acks", 64'({done, fail}), 64'b10);
    prev = station_addr; lat = 1;
    run_seq(-1, prev);
    chk(fail && req_cycles == 1, "R10 zero limit, one-cycle latency", 64'({fail, 8'(req_cycles)}), 64'h101);

    // R9 a success after a failure clears load_fail; R8 accept keeps addr_loaded
    lat = 0; tcyc = 16'd8; load_good(8'h00);
    step(1'b1);
    step(1'b0);
    chk(busy && !loaded && !fail && !done, "R8 R9 flags on acceptance", 64'({busy, loaded, fail, done}), 64'b1000);
    while (m_busy) step(1'b0);
    step(1'b0);
    chk(done && loaded && !fail, "R9 success after failure", 64'({done, loaded, fail}), 64'b110);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule